// File: doc/BRIEF.md
# Transfer Descriptor Buffer Address Unit

This block works out the data-buffer arithmetic for a general transfer descriptor in a USB host controller. A descriptor names its buffer with two 32-bit addresses: the current pointer (first byte still to move) and the end address (last byte of the buffer). The buffer may sit inside one 4 KB page or run over into a second page. When it does, the bytes after the page boundary continue at offset zero of the page that holds the end address, not at the next sequential address.

A command carries the two addresses, the direction (IN or not), the endpoint maximum packet size and the number of bytes to move now. One cycle after the command is accepted the unit presents the total buffer length and the packet length. It then hands one or two address/length segments to a DMA engine over a valid/ready handshake, marking the final one. When the engine reports how many bytes actually moved, the unit returns the pointer value to write back into the descriptor.

Top module: `td_bufaddr_unit`

## Requirements
- R1: When the current pointer or the end address is zero, the total length and the packet length are both 0.
- R2: When address bits 31:12 of the pointer and the end differ, the total length is (end & 0xFFF) + 0x1001 - (pointer & 0xFFF).
- R3: When address bits 31:12 of the pointer and the end are equal, the total length is end - pointer + 1.
- R4: With cmd_dir_in = 0 (SETUP or OUT) the packet length is the smaller of the total length and cmd_mps; with cmd_dir_in = 1 it equals the total length. Both lengths appear on the cycle after the command is accepted.
- R5: The first segment starts at the pointer, with length min(0x1000 - (pointer & 0xFFF), requested length), and appears on the cycle after the command is accepted.
- R6: If bytes remain after the first segment, a second segment follows at the end address with bits 11:0 cleared, carrying the remainder; seg_last is 1 only on the final segment, and seg_valid drops after the final handshake.
- R7: A requested length of zero produces no segment at all.
- R8: seg_err is 1 on any segment whose address is zero.
- R9: A segment held with seg_ready low keeps its address and length unchanged, and cmd_ready is low while any segment is pending.
- R10: One cycle after upd_valid, new_cbp_valid is 1; if (pointer & 0xFFF) + count is at most 0xFFF, new_cbp is pointer + count.
- R11: If (pointer & 0xFFF) + count exceeds 0xFFF, new_cbp is (end & ~0xFFF) + ((pointer + count) & 0xFFF).
- R12: If the count equals the total length, new_cbp is 0.
- R13: After reset, seg_valid and new_cbp_valid are 0, both lengths are 0 and cmd_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_cbp | input | ADDR_W | Current buffer pointer |
| cmd_be | input | ADDR_W | Buffer end address |
| cmd_dir_in | input | 1 | 1 for IN, 0 for SETUP or OUT |
| cmd_mps | input | MPS_W | Endpoint maximum packet size |
| cmd_req | input | LEN_W | Bytes to move in this transfer |
| total_len | output | LEN_W | Total buffer length |
| pkt_len | output | LEN_W | Packet length |
| seg_valid | output | 1 | Segment present |
| seg_ready | input | 1 | DMA engine takes the segment |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment byte count |
| seg_last | output | 1 | Final segment of the command |
| seg_err | output | 1 | Segment address is zero |
| upd_valid | input | 1 | Transfer count strobe |
| upd_count | input | LEN_W | Bytes actually moved |
| new_cbp_valid | output | 1 | Write-back pointer present |
| new_cbp | output | ADDR_W | Pointer value to write back |

## Verification
The vectors separate a buffer inside one page from one that wraps to the end page, and a wrap where the tail lands at a page base far from the next sequential page shows whether the second address really comes from the end address. Packet length is tried with small and full-size packet limits in both directions, so a swapped direction or a missing minimum shows up. Zero pointer, zero end and zero request tell the no-buffer, null-segment and no-segment cases apart, and the write-back counts cover an in-page advance, a wrap into the end page and a full completion. A directed back-pressure run checks that a stalled segment holds and that commands are refused meanwhile.

// File: rtl/td_buf_pkg.sv
package td_buf_pkg;
  typedef enum logic [1:0] {
    SG_IDLE   = 2'd0,
    SG_FIRST  = 2'd1,
    SG_SECOND = 2'd2
  } seg_state_e;
endpackage

// File: rtl/td_len_calc.sv
module td_len_calc #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int MPS_W  = 11,
  parameter int LEN_W  = 14
) (
  input  logic [ADDR_W-1:0] cbp,
  input  logic [ADDR_W-1:0] be,
  input  logic              dir_in,
  input  logic [MPS_W-1:0]  mps,
  output logic [LEN_W-1:0]  total,
  output logic [LEN_W-1:0]  pkt
);
  logic [LEN_W-1:0]  wrap_len, flat_len, mps_ext;
  logic [ADDR_W-1:0] span;
  logic              no_buf, wraps;

  always_comb begin
    no_buf   = (cbp == '0) || (be == '0);
    wraps    = cbp[ADDR_W-1:PAGE_W] != be[ADDR_W-1:PAGE_W];
    wrap_len = LEN_W'(be[PAGE_W-1:0]) + LEN_W'((1 << PAGE_W) + 1)
             - LEN_W'(cbp[PAGE_W-1:0]);
    span     = be - cbp;
    flat_len = span[LEN_W-1:0] + LEN_W'(1);
    total    = no_buf ? '0 : (wraps ? wrap_len : flat_len);
    mps_ext  = LEN_W'(mps);
    pkt      = dir_in ? total : ((mps_ext < total) ? mps_ext : total);
  end
endmodule

// File: rtl/td_seg_gen.sv
module td_seg_gen
  import td_buf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cbp,
  input  logic [ADDR_W-1:0] be,
  input  logic [LEN_W-1:0]  req,
  output logic              busy,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_last,
  output logic              seg_err
);
  seg_state_e        state;
  logic [LEN_W-1:0]  room, rem_len;
  logic [ADDR_W-1:0] page_base;
  logic              take;

  assign room      = LEN_W'(1 << PAGE_W) - LEN_W'(cbp[PAGE_W-1:0]);
  assign take      = seg_valid && seg_ready;
  assign seg_valid = (state != SG_IDLE);
  assign busy      = seg_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SG_IDLE;
      seg_addr  <= '0;
      seg_len   <= '0;
      seg_last  <= 1'b0;
      seg_err   <= 1'b0;
      rem_len   <= '0;
      page_base <= '0;
    end else begin
      case (state)
        SG_IDLE: if (start && req != '0) begin
          state     <= SG_FIRST;
          seg_addr  <= cbp;
          seg_err   <= (cbp == '0);
          page_base <= {be[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
          if (req <= room) begin
            seg_len  <= req;
            seg_last <= 1'b1;
            rem_len  <= '0;
          end else begin
            seg_len  <= room;
            seg_last <= 1'b0;
            rem_len  <= req - room;
          end
        end
        SG_FIRST: if (take) begin
          if (seg_last) begin
            state <= SG_IDLE;
          end else begin
            state    <= SG_SECOND;
            seg_addr <= page_base;
            seg_len  <= rem_len;
            seg_last <= 1'b1;
            seg_err  <= (page_base == '0);
          end
        end
        SG_SECOND: if (take) state <= SG_IDLE;
        default: state <= SG_IDLE;
      endcase
    end
  end

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len)); // R9
  AST_SEG_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> seg_len != '0); // R7
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    seg_valid && seg_ready && seg_last |=> !seg_valid); // R6
  AST_NULL_FLAG: assert property (@(posedge clk) disable iff (rst)
    seg_valid && seg_addr == '0 |-> seg_err); // R8
endmodule

// File: rtl/td_cbp_update.sv
module td_cbp_update #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [LEN_W-1:0]  upd_count,
  input  logic [ADDR_W-1:0] cbp,
  input  logic [ADDR_W-1:0] be,
  input  logic [LEN_W-1:0]  total,
  output logic              new_valid,
  output logic [ADDR_W-1:0] new_cbp
);
  logic [LEN_W:0]    off_sum;
  logic [ADDR_W-1:0] flat_next, next_val;
  logic              crosses;

  always_comb begin
    off_sum   = (LEN_W+1)'(cbp[PAGE_W-1:0]) + (LEN_W+1)'(upd_count);
    crosses   = off_sum > (LEN_W+1)'((1 << PAGE_W) - 1);
    flat_next = cbp + ADDR_W'(upd_count);
    if (upd_count == total)
      next_val = '0;
    else if (crosses)
      next_val = {be[ADDR_W-1:PAGE_W], flat_next[PAGE_W-1:0]};
    else
      next_val = flat_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      new_valid <= 1'b0;
      new_cbp   <= '0;
    end else begin
      new_valid <= upd_valid;
      if (upd_valid) new_cbp <= next_val;
    end
  end

  AST_WB_TIMING: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> new_valid); // R10
  AST_WB_SOLO: assert property (@(posedge clk) disable iff (rst)
    new_valid |-> $past(upd_valid)); // R10
endmodule

// File: rtl/td_bufaddr_unit.sv
module td_bufaddr_unit #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int MPS_W  = 11,
  localparam int LEN_W = PAGE_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_cbp,
  input  logic [ADDR_W-1:0] cmd_be,
  input  logic              cmd_dir_in,
  input  logic [MPS_W-1:0]  cmd_mps,
  input  logic [LEN_W-1:0]  cmd_req,
  output logic [LEN_W-1:0]  total_len,
  output logic [LEN_W-1:0]  pkt_len,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_last,
  output logic              seg_err,
  input  logic              upd_valid,
  input  logic [LEN_W-1:0]  upd_count,
  output logic              new_cbp_valid,
  output logic [ADDR_W-1:0] new_cbp
);
  logic [LEN_W-1:0]  calc_total, calc_pkt;
  logic [ADDR_W-1:0] d_cbp, d_be;
  logic              busy, accept;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  td_len_calc #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .MPS_W(MPS_W), .LEN_W(LEN_W)) u_len (
    .cbp(cmd_cbp), .be(cmd_be), .dir_in(cmd_dir_in), .mps(cmd_mps),
    .total(calc_total), .pkt(calc_pkt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      total_len <= '0;
      pkt_len   <= '0;
      d_cbp     <= '0;
      d_be      <= '0;
    end else if (accept) begin
      total_len <= calc_total;
      pkt_len   <= calc_pkt;
      d_cbp     <= cmd_cbp;
      d_be      <= cmd_be;
    end
  end

  td_seg_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_seg (
    .clk(clk), .rst(rst), .start(accept), .cbp(cmd_cbp), .be(cmd_be), .req(cmd_req),
    .busy(busy), .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last), .seg_err(seg_err)
  );

  td_cbp_update #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_upd (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_count(upd_count),
    .cbp(d_cbp), .be(d_be), .total(total_len),
    .new_valid(new_cbp_valid), .new_cbp(new_cbp)
  );

  AST_PKT_LE_TOTAL: assert property (@(posedge clk) disable iff (rst)
    pkt_len <= total_len); // R4
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> !cmd_ready); // R9
  AST_IDLE_LENS: assert property (@(posedge clk) disable iff (rst)
    (total_len == '0) |-> (pkt_len == '0)); // R1
endmodule

// File: tb/tb_td_bufaddr_unit.sv
module tb_td_bufaddr_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid, cmd_ready, cmd_dir_in;
  logic [31:0] cmd_cbp, cmd_be;
  logic [10:0] cmd_mps;
  logic [13:0] cmd_req, total_len, pkt_len, seg_len, upd_count;
  logic        seg_valid, seg_ready, seg_last, seg_err, upd_valid, new_cbp_valid;
  logic [31:0] seg_addr, new_cbp;

  always #5 clk = ~clk;

  td_bufaddr_unit dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_cbp(cmd_cbp), .cmd_be(cmd_be), .cmd_dir_in(cmd_dir_in), .cmd_mps(cmd_mps),
    .cmd_req(cmd_req), .total_len(total_len), .pkt_len(pkt_len),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last), .seg_err(seg_err),
    .upd_valid(upd_valid), .upd_count(upd_count),
    .new_cbp_valid(new_cbp_valid), .new_cbp(new_cbp)
  );

  typedef struct packed {
    logic [31:0] cbp;  logic [31:0] be;   logic din;  logic [10:0] mps;
    logic [13:0] req;  logic [13:0] tot;  logic [13:0] pkt; logic [1:0] nseg;
    logic [13:0] l1;   logic [13:0] l2;   logic e1;   logic e2;
    logic [13:0] n;    logic [31:0] ncbp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0001_0100, 32'h0001_01FF, 1'b0, 11'd64,    14'd64,   14'h100, 14'd64,   2'd1, 14'd64,   14'd0,  1'b0, 1'b0, 14'd64,   32'h0001_0140},
    '{32'h0002_0F80, 32'h0005_007F, 1'b1, 11'd8,     14'h100,  14'h100, 14'h100,  2'd2, 14'h80,   14'h80, 1'b0, 1'b0, 14'h100,  32'h0000_0000},
    '{32'h0003_0FF0, 32'h0007_0100, 1'b0, 11'h20,    14'h20,   14'h111, 14'h20,   2'd2, 14'h10,   14'h10, 1'b0, 1'b0, 14'h20,   32'h0007_0010},
    '{32'h0000_0000, 32'h0000_1234, 1'b1, 11'd8,     14'd0,    14'd0,   14'd0,    2'd0, 14'd0,    14'd0,  1'b0, 1'b0, 14'd0,    32'h0000_0000},
    '{32'h0000_0000, 32'h0000_0010, 1'b0, 11'd16,    14'd4,    14'd0,   14'd0,    2'd1, 14'd4,    14'd0,  1'b1, 1'b0, 14'd0,    32'h0000_0000},
    '{32'h0000_1FF8, 32'h0000_0004, 1'b0, 11'h7FF,   14'hD,    14'hD,   14'hD,    2'd2, 14'd8,    14'd5,  1'b0, 1'b1, 14'd8,    32'h0000_0000},
    '{32'h0008_0000, 32'h0008_0FFF, 1'b0, 11'h7FF,   14'h1000, 14'h1000,14'h7FF,  2'd1, 14'h1000, 14'd0,  1'b0, 1'b0, 14'h7FF,  32'h0008_07FF}
  };

  int  n_chk = 0, n_fail = 0;
  bit  finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input vec_t v);
    @(negedge clk);
    cmd_cbp = v.cbp; cmd_be = v.be; cmd_dir_in = v.din;
    cmd_mps = v.mps; cmd_req = v.req; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    seg_ready = 1'b1;
    send_cmd(v);
    chk($sformatf("R1/R2/R3 total v%0d", idx), 32'(total_len), 32'(v.tot));
    chk($sformatf("R4 pkt v%0d", idx), 32'(pkt_len), 32'(v.pkt));
    if (v.nseg == 2'd0) begin
      chk($sformatf("R7 no segment v%0d", idx), 32'(seg_valid), 32'd0);
    end else begin
      chk($sformatf("R5 seg1 valid v%0d", idx), 32'(seg_valid), 32'd1);
      chk($sformatf("R5 seg1 addr v%0d", idx), seg_addr, v.cbp);
      chk($sformatf("R5 seg1 len v%0d", idx), 32'(seg_len), 32'(v.l1));
      chk($sformatf("R6 seg1 last v%0d", idx), 32'(seg_last), 32'(v.nseg == 2'd1));
      chk($sformatf("R8 seg1 err v%0d", idx), 32'(seg_err), 32'(v.e1));
      chk($sformatf("R9 busy v%0d", idx), 32'(cmd_ready), 32'd0);
      @(posedge clk); @(negedge clk);
      if (v.nseg == 2'd2) begin
        chk($sformatf("R6 seg2 valid v%0d", idx), 32'(seg_valid), 32'd1);
        chk($sformatf("R6 seg2 addr v%0d", idx), seg_addr, {v.be[31:12], 12'h000});
        chk($sformatf("R6 seg2 len v%0d", idx), 32'(seg_len), 32'(v.l2));
        chk($sformatf("R6 seg2 last v%0d", idx), 32'(seg_last), 32'd1);
        chk($sformatf("R8 seg2 err v%0d", idx), 32'(seg_err), 32'(v.e2));
        @(posedge clk); @(negedge clk);
      end
      chk($sformatf("R6 drop after last v%0d", idx), 32'(seg_valid), 32'd0);
    end
    chk($sformatf("R9 ready again v%0d", idx), 32'(cmd_ready), 32'd1);
    upd_valid = 1'b1; upd_count = v.n;
    @(posedge clk); @(negedge clk);
    upd_valid = 1'b0;
    chk($sformatf("R10 wb valid v%0d", idx), 32'(new_cbp_valid), 32'd1);
    chk($sformatf("R10/R11/R12 new pointer v%0d", idx), new_cbp, v.ncbp);
    @(negedge clk);
    chk($sformatf("R10 wb pulse v%0d", idx), 32'(new_cbp_valid), 32'd0);
  endtask

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_cbp = '0; cmd_be = '0; cmd_dir_in = 1'b0;
    cmd_mps = '0; cmd_req = '0; seg_ready = 1'b0; upd_valid = 1'b0; upd_count = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    chk("R13 seg_valid", 32'(seg_valid), 32'd0);
    chk("R13 new_cbp_valid", 32'(new_cbp_valid), 32'd0);
    chk("R13 total", 32'(total_len), 32'd0);
    chk("R13 cmd_ready", 32'(cmd_ready), 32'd1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R9 back-pressure: segment holds, commands refused
    seg_ready = 1'b0;
    send_cmd(VECS[2]);
    for (int k = 0; k < 3; k++) begin
      chk("R9 hold valid", 32'(seg_valid), 32'd1);
      chk("R9 hold addr", seg_addr, 32'h0003_0FF0);
      chk("R9 hold len", 32'(seg_len), 32'h10);
      chk("R9 cmd refused", 32'(cmd_ready), 32'd0);
      @(negedge clk);
    end
    seg_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 seg2 after stall", seg_addr, 32'h0007_0000);
    @(posedge clk); @(negedge clk);
    chk("R9 idle after stall", 32'(cmd_ready), 32'd1);

    // R11 wrap write-back with a partial count from the earlier descriptor
    upd_valid = 1'b1; upd_count = 14'h10;
    @(posedge clk); @(negedge clk);
    upd_valid = 1'b0;
    chk("R11 wrap to end page base", new_cbp, 32'h0007_0000);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R13 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule